// File: doc/BRIEF.md
# Suspicious Signature Confirmation Table

This block sits behind a bank of on-chip occurrence counters. Whenever one of those counters passes its threshold, it hands over an event: the 80-bit byte string that tripped it and a short table index derived from that string. The block keeps a small table of candidate strings, one per index, each with an occurrence count. Every event reads its slot and compares the stored string with the new one bit for bit. An identical string raises the count; a different string takes over the slot and restarts its count. Hash aliasing therefore never adds up sightings of two different strings.

When a slot's count reaches the programmable confirmation level, the block sends the full string to the downstream alert generator as a one-cycle pulse. It then marks the slot as reported, so further copies of that string raise no more alerts until a different string evicts it. The table is an internal memory with a two-cycle read latency. Events arrive on a valid/ready handshake, and the block stays busy while a read-modify-write is in flight.

The control is a three-state machine. `ST_IDLE` raises `ev_ready`. On an accepted event it issues the read and moves to `ST_FETCH`. `ST_FETCH` waits for the read data, latches the stored entry and moves to `ST_APPLY`. `ST_APPLY` writes the updated entry, raises the alert if one is due, and returns to `ST_IDLE`.

Top module: `sig_confirm_table`

## Requirements
- R1: After reset `ev_ready` is 1, `alert_valid` is 0, and every table slot is empty.
- R2: An event is accepted on a rising edge where `ev_valid` and `ev_ready` are both 1. `ev_ready` is then 0 in the next three cycles and 1 again in the fourth, so the block takes at most one event every four cycles.
- R3: An event at an empty slot stores its string with a count of 1 and raises no alert, unless the effective level is 1.
- R4: An event whose string exactly equals the stored, not yet reported string raises that slot's count by one. The count saturates at its maximum. If the new count is at least the effective level, an alert is raised.
- R5: An alert shows the full 80-bit event string on `alert_sig` while `alert_valid` is 1.
- R6: An event whose string differs from a valid stored string overwrites the slot with the new string and a count of 1, and clears the reported mark. The evicted string must then collect the full level again.
- R7: Once a slot has raised an alert, further identical events at that slot raise no alert.
- R8: A `confirm_level` of 0 behaves as 1: every first sighting confirms at once.
- R9: Slots are independent. Events at one index never change the count or string held at another index.
- R10: An alert is a single-cycle pulse. It appears in the fourth cycle after the accepting edge, together with `ev_ready` returning to 1, and at most one alert is raised per accepted event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Threshold-crossing event offered |
| ev_ready | output | 1 | Block can accept an event this cycle |
| ev_sig | input | 80 | Byte string of the event |
| ev_idx | input | 4 | Table slot index computed from the string |
| confirm_level | input | 8 | Count at which a slot is confirmed (0 treated as 1) |
| alert_valid | output | 1 | One-cycle pulse: confirmed string on `alert_sig` |
| alert_sig | output | 80 | Confirmed byte string |

## Verification
The hardest situation to reach is the eviction of a string that has already been partly counted or reported, followed by that string's return. The stored count is never visible at the ports, so it shows only through the exact event on which the alert fires. The stimulus sweeps all sixteen slots with levels 1 to 5. Each slot gets a run past its level, then an intruding string, then the original string again, so the alert position shows that the count restarted. Short interleaved runs on two slots and a level of zero round this out.

// File: rtl/sct_pkg.sv
package sct_pkg;

    // Control states of the confirmation table.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_APPLY = 2'd2
    } sct_state_e;

endpackage

// File: rtl/sct_store.sv
// Table storage: one entry per index, holding a valid flag, a reported flag,
// a count and the string. Reads return after RD_LAT cycles.
module sct_store #(
    parameter int SIG_W  = 80,
    parameter int CNT_W  = 8,
    parameter int IDX_W  = 4,
    parameter int RD_LAT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_addr,
    output logic             rd_vld,
    output logic             rd_ent_vld,
    output logic             rd_ent_rep,
    output logic [CNT_W-1:0] rd_ent_cnt,
    output logic [SIG_W-1:0] rd_ent_sig,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_addr,
    input  logic [CNT_W-1:0] wr_cnt,
    input  logic             wr_rep,
    input  logic [SIG_W-1:0] wr_sig
);

    localparam int DEPTH = 1 << IDX_W;
    localparam int ENT_W = 2 + CNT_W + SIG_W;

    logic [DEPTH-1:0] vld_q;
    logic [DEPTH-1:0] rep_q;
    logic [SIG_W-1:0] sig_mem [DEPTH];
    logic [CNT_W-1:0] cnt_mem [DEPTH];

    logic [ENT_W-1:0] pipe_d [RD_LAT];
    logic [RD_LAT-1:0] pipe_v;

    // Flags carry a reset so the table starts empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            rep_q <= '0;
        end else if (wr_en) begin
            vld_q[wr_addr] <= 1'b1;
            rep_q[wr_addr] <= wr_rep;
        end
    end

    // Payload arrays need no reset: they are ignored while the flag is clear.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            sig_mem[wr_addr] <= wr_sig;
            cnt_mem[wr_addr] <= wr_cnt;
        end
    end

    // First read stage.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe_v[0] <= 1'b0;
        else        pipe_v[0] <= rd_en;
    end

    always_ff @(posedge clk) begin
        pipe_d[0] <= {vld_q[rd_addr], rep_q[rd_addr], cnt_mem[rd_addr], sig_mem[rd_addr]};
    end

    // Further read stages up to the configured latency.
    genvar g;
    generate
        for (g = 1; g < RD_LAT; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) pipe_v[g] <= 1'b0;
                else        pipe_v[g] <= pipe_v[g-1];
            end
            always_ff @(posedge clk) begin
                pipe_d[g] <= pipe_d[g-1];
            end
        end
    endgenerate

    assign rd_vld = pipe_v[RD_LAT-1];
    assign {rd_ent_vld, rd_ent_rep, rd_ent_cnt, rd_ent_sig} = pipe_d[RD_LAT-1];

endmodule

// File: rtl/sct_decide.sv
// Update rule for one entry: compare, count, evict, confirm.
module sct_decide #(
    parameter int SIG_W = 80,
    parameter int CNT_W = 8
) (
    input  logic             ent_vld,
    input  logic             ent_rep,
    input  logic [CNT_W-1:0] ent_cnt,
    input  logic [SIG_W-1:0] ent_sig,
    input  logic [SIG_W-1:0] new_sig,
    input  logic [CNT_W-1:0] level,
    output logic             do_write,
    output logic             do_alert,
    output logic [CNT_W-1:0] nxt_cnt,
    output logic             nxt_rep
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic             same;
    logic [CNT_W-1:0] eff_level;
    logic [CNT_W-1:0] bumped;

    assign same      = ent_vld && (ent_sig == new_sig);
    assign eff_level = (level == '0) ? ONE : level;
    assign bumped    = (ent_cnt == '1) ? ent_cnt : ent_cnt + ONE;

    always_comb begin
        if (!same) begin
            // Empty slot or different string: take over the slot.
            do_write = 1'b1;
            nxt_cnt  = ONE;
            do_alert = (eff_level == ONE);
            nxt_rep  = do_alert;
        end else if (ent_rep) begin
            // Already reported: leave the entry untouched.
            do_write = 1'b0;
            nxt_cnt  = ent_cnt;
            do_alert = 1'b0;
            nxt_rep  = 1'b1;
        end else begin
            do_write = 1'b1;
            nxt_cnt  = bumped;
            do_alert = (bumped >= eff_level);
            nxt_rep  = do_alert;
        end
    end

endmodule

// File: rtl/sig_confirm_table.sv
// Confirms repeated suspicious strings by exact comparison against a table.
module sig_confirm_table #(
    parameter int SIG_W  = 80,
    parameter int CNT_W  = 8,
    parameter int IDX_W  = 4,
    parameter int RD_LAT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_valid,
    output logic             ev_ready,
    input  logic [SIG_W-1:0] ev_sig,
    input  logic [IDX_W-1:0] ev_idx,
    input  logic [CNT_W-1:0] confirm_level,
    output logic             alert_valid,
    output logic [SIG_W-1:0] alert_sig
);

    import sct_pkg::*;

    sct_state_e state_q, state_d;

    logic [SIG_W-1:0] req_sig_q;
    logic [IDX_W-1:0] req_idx_q;
    logic             ent_vld_q, ent_rep_q;
    logic [CNT_W-1:0] ent_cnt_q;
    logic [SIG_W-1:0] ent_sig_q;

    logic             rd_en, rd_vld;
    logic             rd_ent_vld, rd_ent_rep;
    logic [CNT_W-1:0] rd_ent_cnt;
    logic [SIG_W-1:0] rd_ent_sig;

    logic             wr_en;
    logic             upd_write, upd_alert, upd_rep;
    logic [CNT_W-1:0] upd_cnt;

    logic             accept;

    assign ev_ready = (state_q == ST_IDLE);
    assign accept   = ev_valid && ev_ready;
    assign rd_en    = accept;
    assign wr_en    = (state_q == ST_APPLY) && upd_write;

    sct_store #(
        .SIG_W (SIG_W),
        .CNT_W (CNT_W),
        .IDX_W (IDX_W),
        .RD_LAT(RD_LAT)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .rd_addr   (ev_idx),
        .rd_vld    (rd_vld),
        .rd_ent_vld(rd_ent_vld),
        .rd_ent_rep(rd_ent_rep),
        .rd_ent_cnt(rd_ent_cnt),
        .rd_ent_sig(rd_ent_sig),
        .wr_en     (wr_en),
        .wr_addr   (req_idx_q),
        .wr_cnt    (upd_cnt),
        .wr_rep    (upd_rep),
        .wr_sig    (req_sig_q)
    );

    sct_decide #(
        .SIG_W(SIG_W),
        .CNT_W(CNT_W)
    ) u_decide (
        .ent_vld (ent_vld_q),
        .ent_rep (ent_rep_q),
        .ent_cnt (ent_cnt_q),
        .ent_sig (ent_sig_q),
        .new_sig (req_sig_q),
        .level   (confirm_level),
        .do_write(upd_write),
        .do_alert(upd_alert),
        .nxt_cnt (upd_cnt),
        .nxt_rep (upd_rep)
    );

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_FETCH;
            ST_FETCH: if (rd_vld) state_d = ST_APPLY;
            ST_APPLY: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Registered outputs and working registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alert_valid <= 1'b0;
            alert_sig   <= '0;
            req_sig_q   <= '0;
            req_idx_q   <= '0;
            ent_vld_q   <= 1'b0;
            ent_rep_q   <= 1'b0;
            ent_cnt_q   <= '0;
            ent_sig_q   <= '0;
        end else begin
            alert_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        req_sig_q <= ev_sig;
                        req_idx_q <= ev_idx;
                    end
                end
                ST_FETCH: begin
                    if (rd_vld) begin
                        ent_vld_q <= rd_ent_vld;
                        ent_rep_q <= rd_ent_rep;
                        ent_cnt_q <= rd_ent_cnt;
                        ent_sig_q <= rd_ent_sig;
                    end
                end
                ST_APPLY: begin
                    if (upd_alert) begin
                        alert_valid <= 1'b1;
                        alert_sig   <= req_sig_q;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/sct_checker.sv
module sct_checker (
    input logic clk,
    input logic rst_n,
    input logic ev_valid,
    input logic ev_ready,
    input logic alert_valid,
    input logic wr_en,
    input logic rd_vld
);

    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_ready) |=> !ev_ready);

    a_r2_no_read_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
        rd_vld |-> !ev_ready);

    a_r10_alert_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        alert_valid |=> !alert_valid);

    a_r10_alert_on_return: assert property (@(posedge clk) disable iff (!rst_n)
        alert_valid |-> (ev_ready && $past(!ev_ready)));

    a_r3_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(rd_vld));

endmodule

bind sig_confirm_table sct_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_valid   (ev_valid),
    .ev_ready   (ev_ready),
    .alert_valid(alert_valid),
    .wr_en      (wr_en),
    .rd_vld     (rd_vld)
);

// File: tb/sig_confirm_table_tb.sv
module sig_confirm_table_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_valid = 1'b0;
    logic        ev_ready;
    logic [79:0] ev_sig = '0;
    logic [3:0]  ev_idx = '0;
    logic [7:0]  confirm_level = 8'd1;
    logic        alert_valid;
    logic [79:0] alert_sig;

    int checks = 0;
    int errors = 0;

    // Bench model of the table, built from the requirements.
    bit          m_vld [16];
    bit          m_rep [16];
    int          m_cnt [16];
    logic [79:0] m_sig [16];

    always #5 clk = ~clk;

    sig_confirm_table u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ev_valid     (ev_valid),
        .ev_ready     (ev_ready),
        .ev_sig       (ev_sig),
        .ev_idx       (ev_idx),
        .confirm_level(confirm_level),
        .alert_valid  (alert_valid),
        .alert_sig    (alert_sig)
    );

    function automatic logic [79:0] sig_of(int a, int b);
        logic [15:0] hi;
        logic [31:0] mid, lo;
        hi  = 16'hA5C3 ^ a[15:0];
        mid = 32'(a * 7919 + b * 31 + 1);
        lo  = 32'(b * 104729) ^ 32'(a);
        return {hi, mid, lo};
    endfunction

    task automatic chk(bit ok, string tag, string what, logic [79:0] act, logic [79:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Offer one event, then check the busy window and the alert cycle.
    task automatic send(int idx, logic [79:0] sig, int lvl);
        int    eff;
        bit    fire;
        string tag;
        eff = (lvl == 0) ? 1 : lvl;
        if (!m_vld[idx] || m_sig[idx] != sig) begin
            tag = m_vld[idx] ? "R6" : "R3";
            m_vld[idx] = 1'b1;
            m_sig[idx] = sig;
            m_cnt[idx] = 1;
            fire = (eff <= 1);
            m_rep[idx] = fire;
        end else if (m_rep[idx]) begin
            tag  = "R7";
            fire = 1'b0;
        end else begin
            tag = "R4";
            if (m_cnt[idx] < 255) m_cnt[idx]++;
            fire = (m_cnt[idx] >= eff);
            m_rep[idx] = fire;
        end
        if (lvl == 0) tag = "R8";

        @(negedge clk);
        confirm_level = 8'(lvl);
        ev_sig   = sig;
        ev_idx   = 4'(idx);
        ev_valid = 1'b1;
        while (!ev_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        ev_valid = 1'b0;
        for (int c = 1; c <= 3; c++) begin
            chk(ev_ready == 1'b0, "R2", "ready during busy", 80'(ev_ready), 80'(0));
            chk(alert_valid == 1'b0, "R10", "alert during busy", 80'(alert_valid), 80'(0));
            @(negedge clk);
        end
        chk(ev_ready == 1'b1, "R2", "ready in fourth cycle", 80'(ev_ready), 80'(1));
        chk(alert_valid == fire, tag, "alert decision", 80'(alert_valid), 80'(fire));
        if (fire)
            chk(alert_sig == sig, "R5", "alert string", alert_sig, sig);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle and quiet after reset.
        chk(ev_ready == 1'b1, "R1", "ready after reset", 80'(ev_ready), 80'(1));
        chk(alert_valid == 1'b0, "R1", "alert after reset", 80'(alert_valid), 80'(0));

        // Sweep every slot with levels 1..5: run past the level (R4, R7),
        // evict with a foreign string (R6), then bring the original back.
        for (int i = 0; i < 16; i++) begin
            int lv;
            lv = (i % 5) + 1;
            for (int k = 0; k < lv + 2; k++) send(i, sig_of(i, 0), lv);
            send(i, sig_of(i, 1), lv);
            for (int k = 0; k < lv; k++) send(i, sig_of(i, 0), lv);
        end

        // R8: level zero confirms on first sighting.
        send(3, sig_of(3, 9), 0);
        send(3, sig_of(3, 9), 0);

        // R9: two slots interleaved, each needs its own three sightings.
        for (int k = 0; k < 3; k++) begin
            send(5, sig_of(5, 20), 3);
            send(6, sig_of(6, 20), 3);
        end

        // R4: lowering the level lets the next match confirm.
        send(7, sig_of(7, 30), 5);
        send(7, sig_of(7, 30), 5);
        send(7, sig_of(7, 30), 2);

        // R6: an eviction at one slot leaves a neighbour's count intact (R9).
        send(8, sig_of(8, 40), 3);
        send(8, sig_of(8, 40), 3);
        send(9, sig_of(9, 41), 3);
        send(8, sig_of(8, 40), 3);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule